// File: doc/BRIEF.md
# Data Integrity Alarm Tracker

This block sits behind the integrity checker of a serial link receiver. Each time a multiblock finishes, the receiver pulses an end strobe and reports on a separate flag whether that multiblock failed its integrity check. The tracker counts failed multiblocks and raises an alarm when the count reaches a programmable threshold. The alarm level also drives the link watchdog.

The alarm has hysteresis. Failed multiblocks do not need to be consecutive to count toward the threshold. Only an unbroken run of clean multiblocks, whose length is also programmable, clears both the count and the alarm. Any failed multiblock restarts that run.

Two 2-bit select inputs choose the threshold and the run length. The block samples its inputs only in cycles that carry the end strobe.

Top module: `dia_alarm_tracker`

## Requirements
- R1: Reset, asserted low at any time, clears the error count, the clean-run progress and the alarm.
- R2: Each end strobe that carries the error flag adds one to the error count on the next clock edge, up to the saturation point given in R4.
- R3: Threshold select codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 failed multiblocks. The alarm goes high on the edge where the count reaches the threshold.
- R4: The error count saturates at the selected threshold. Further failed multiblocks leave it there.
- R5: Recovery select codes 0, 1, 2 and 3 mean 1, 4, 16 and 64 contiguous clean multiblocks. Completing the run clears the count to zero and drops the alarm on that edge.
- R6: A failed multiblock restarts the clean run, so clean multiblocks counted before it do not count toward recovery.
- R7: With the end strobe low, the error flag has no effect on the count or the alarm.
- R8: A clean run shorter than the recovery length leaves the alarm and the count unchanged.
- R9: Failed multiblocks separated by clean runs shorter than the recovery length still add up and can raise the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mb_end_i | input | 1 | Multiblock-end strobe, one cycle per multiblock |
| mb_err_i | input | 1 | Integrity error flag for the multiblock that is ending |
| thresh_sel_i | input | 2 | Threshold select code (1, 2, 4 or 8 failures) |
| recov_sel_i | input | 2 | Recovery select code (1, 4, 16 or 64 clean multiblocks) |
| alarm_o | output | 1 | Integrity alarm level |
| err_cnt_o | output | 4 | Current failed-multiblock count |

## Verification
The bound checker tests these rules on every cycle:
- Without a strobe, neither output moves.
- The count only ever grows by one.
- The alarm only rises on a failed strobe and only falls on a clean strobe, and when it falls the count is zero.
- A failed strobe that reaches the threshold raises the alarm.
- With a one-multiblock recovery, a single clean strobe clears everything.

The longer recovery runs of 4, 16 and 64 depend on how many strobes came before, so only the bench scenarios can show them. The same is true of a run restarted by an error, and of errors spread between short clean runs adding up to the threshold.

// File: rtl/dia_pkg.sv
package dia_pkg;
  // Threshold code k selects 2**k failed multiblocks.
  function automatic int unsigned thr_count(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Recovery code k selects 4**k clean multiblocks.
  function automatic int unsigned run_count(input int unsigned code);
    return 32'd1 << (2 * code);
  endfunction
endpackage

// File: rtl/dia_run_counter.sv
module dia_run_counter #(
  parameter int unsigned RUN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mb_end_i,
  input  logic             mb_err_i,
  input  logic [RUN_W-1:0] run_len_i,
  output logic             recover_o
);
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;

  always_comb begin
    run_inc   = run_q + 1'b1;
    recover_o = mb_end_i & ~mb_err_i & (run_inc >= run_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (mb_end_i) begin
      if (mb_err_i || recover_o) run_q <= '0;
      else                       run_q <= run_inc;
    end
  end
endmodule

// File: rtl/dia_err_accum.sv
module dia_err_accum #(
  parameter int unsigned ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mb_end_i,
  input  logic             mb_err_i,
  input  logic             recover_i,
  input  logic [ERR_W-1:0] thr_i,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             alarm_o
);
  logic [ERR_W-1:0] cnt_q;
  logic [ERR_W-1:0] cnt_nxt;
  logic             alarm_q;

  // saturate at the active threshold
  always_comb begin
    if (cnt_q >= thr_i) cnt_nxt = thr_i;
    else                cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else if (mb_end_i) begin
      if (mb_err_i) begin
        cnt_q   <= cnt_nxt;
        alarm_q <= alarm_q | (cnt_nxt >= thr_i);
      end else if (recover_i) begin
        cnt_q   <= '0;
        alarm_q <= 1'b0;
      end
    end
  end

  assign err_cnt_o = cnt_q;
  assign alarm_o   = alarm_q;
endmodule

// File: rtl/dia_alarm_tracker.sv
module dia_alarm_tracker #(
  parameter int unsigned CODE_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mb_end_i,
  input  logic                 mb_err_i,
  input  logic [CODE_W-1:0]    thresh_sel_i,
  input  logic [CODE_W-1:0]    recov_sel_i,
  output logic                 alarm_o,
  output logic [3:0]           err_cnt_o
);
  localparam int unsigned NCODES  = 1 << CODE_W;
  localparam int unsigned MAX_THR = dia_pkg::thr_count(NCODES - 1);
  localparam int unsigned MAX_RUN = dia_pkg::run_count(NCODES - 1);
  localparam int unsigned ERR_W   = $clog2(MAX_THR + 1);
  localparam int unsigned RUN_W   = $clog2(MAX_RUN + 1);

  logic [ERR_W-1:0] thr_val;
  logic [RUN_W-1:0] run_len;
  logic             recover;
  logic [ERR_W-1:0] cnt;

  assign thr_val = ERR_W'(dia_pkg::thr_count(32'(thresh_sel_i)));
  assign run_len = RUN_W'(dia_pkg::run_count(32'(recov_sel_i)));

  dia_run_counter #(.RUN_W(RUN_W)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mb_end_i  (mb_end_i),
    .mb_err_i  (mb_err_i),
    .run_len_i (run_len),
    .recover_o (recover)
  );

  dia_err_accum #(.ERR_W(ERR_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mb_end_i  (mb_end_i),
    .mb_err_i  (mb_err_i),
    .recover_i (recover),
    .thr_i     (thr_val),
    .err_cnt_o (cnt),
    .alarm_o   (alarm_o)
  );

  assign err_cnt_o = 4'(cnt);
endmodule

// File: rtl/dia_alarm_tracker_chk.sv
module dia_alarm_tracker_chk #(
  parameter int unsigned CODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mb_end_i,
  input logic              mb_err_i,
  input logic [CODE_W-1:0] thresh_sel_i,
  input logic [CODE_W-1:0] recov_sel_i,
  input logic              alarm_o,
  input logic [3:0]        err_cnt_o
);
  logic [4:0] thr_w;
  logic [4:0] cnt_plus;

  always_comb begin
    thr_w    = 5'd1 << thresh_sel_i;
    cnt_plus = {1'b0, err_cnt_o} + 5'd1;
  end

  // R7: no strobe, no change
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mb_end_i |=> ($stable(alarm_o) && $stable(err_cnt_o)));

  // R2: count grows by exactly one when it grows
  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o > $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + 4'd1));

  // R3: reaching the threshold raises the alarm
  assert_alarm_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_end_i && mb_err_i && (cnt_plus >= thr_w)) |=> alarm_o);

  assert_rise_on_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(mb_end_i && mb_err_i));

  // R5: alarm falls only on a clean strobe, together with the count
  assert_fall_on_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> ($past(mb_end_i && !mb_err_i) && err_cnt_o == 4'd0));

  assert_single_recov_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_end_i && !mb_err_i && recov_sel_i == '0) |=> (!alarm_o && err_cnt_o == 4'd0));

  // R6: an errored strobe leaves a nonzero count
  assert_err_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_end_i && mb_err_i) |=> (err_cnt_o != 4'd0));
endmodule

bind dia_alarm_tracker dia_alarm_tracker_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mb_end_i     (mb_end_i),
  .mb_err_i     (mb_err_i),
  .thresh_sel_i (thresh_sel_i),
  .recov_sel_i  (recov_sel_i),
  .alarm_o      (alarm_o),
  .err_cnt_o    (err_cnt_o)
);

// File: tb/tb_dia_alarm_tracker.sv
module tb_dia_alarm_tracker;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mb_end = 1'b0;
  logic       mb_err = 1'b0;
  logic [1:0] thr_sel = 2'd0;
  logic [1:0] rec_sel = 2'd0;
  logic       alarm;
  logic [3:0] cnt;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dia_alarm_tracker dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .mb_end_i     (mb_end),
    .mb_err_i     (mb_err),
    .thresh_sel_i (thr_sel),
    .recov_sel_i  (rec_sel),
    .alarm_o      (alarm),
    .err_cnt_o    (cnt)
  );

  // {end, err, thr_sel, rec_sel, exp_alarm, exp_cnt}; thr 2, recovery 4
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    11'b1_1_01_01_0_0001,  // R2 first error
    11'b1_0_01_01_0_0001,  // clean, run 1
    11'b0_1_01_01_0_0001,  // R7 flag without strobe
    11'b1_1_01_01_1_0010,  // R3 threshold reached
    11'b1_1_01_01_1_0010,  // R4 saturate
    11'b1_0_01_01_1_0010,  // R8 run 1
    11'b1_0_01_01_1_0010,  // R8 run 2
    11'b1_0_01_01_1_0010,  // R8 run 3
    11'b1_1_01_01_1_0010,  // R6 restart run
    11'b1_0_01_01_1_0010,
    11'b1_0_01_01_1_0010,
    11'b1_0_01_01_1_0010,
    11'b1_0_01_01_0_0000,  // R5 fourth clean clears
    11'b1_0_01_01_0_0000,
    11'b1_1_01_01_0_0001,  // R9 spread errors
    11'b1_0_01_01_0_0001,
    11'b1_0_01_01_0_0001,
    11'b1_0_01_01_0_0001,
    11'b1_1_01_01_1_0010   // R9 accumulates to alarm
  };

  task automatic chk(input string tag, input logic ea, input logic [3:0] ec);
    checks++;
    if (alarm !== ea || cnt !== ec) begin
      errors++;
      $display("FAIL %s: alarm=%0b cnt=%0d expected alarm=%0b cnt=%0d",
               tag, alarm, cnt, ea, ec);
    end
  endtask

  task automatic mb(input logic err, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      mb_end = 1'b1;
      mb_err = err;
      @(negedge clk);
      mb_end = 1'b0;
      mb_err = 1'b0;
    end
  endtask

  task automatic do_reset(input logic [1:0] t, input logic [1:0] r);
    @(negedge clk);
    rst_ni  = 1'b0;
    thr_sel = t;
    rec_sel = r;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    do_reset(2'd1, 2'd1);
    chk("R1 reset state", 1'b0, 4'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mb_end, mb_err, thr_sel, rec_sel} = VEC[i][10:5];
      @(negedge clk);
      chk($sformatf("table step %0d (R2/R3/R4/R5/R6/R7/R8/R9)", i), VEC[i][4], VEC[i][3:0]);
      mb_end = 1'b0;
      mb_err = 1'b0;
    end

    // R3 / R4: threshold of 8, recovery of 64
    do_reset(2'd3, 2'd3);
    mb(1'b1, 7);
    chk("R3 below threshold 8", 1'b0, 4'd7);
    mb(1'b1, 1);
    chk("R3 threshold 8 reached", 1'b1, 4'd8);
    mb(1'b1, 2);
    chk("R4 saturate at 8", 1'b1, 4'd8);
    mb(1'b0, 63);
    chk("R8 63 of 64 clean", 1'b1, 4'd8);
    mb(1'b0, 1);
    chk("R5 64 clean clears", 1'b0, 4'd0);

    // R3 threshold 1, R5 recovery 16
    do_reset(2'd0, 2'd2);
    mb(1'b1, 1);
    chk("R3 threshold 1", 1'b1, 4'd1);
    mb(1'b0, 15);
    chk("R8 15 of 16 clean", 1'b1, 4'd1);
    mb(1'b0, 1);
    chk("R5 16 clean clears", 1'b0, 4'd0);

    // R3 threshold 4, R5 recovery 1
    do_reset(2'd2, 2'd0);
    mb(1'b1, 3);
    chk("R3 below threshold 4", 1'b0, 4'd3);
    mb(1'b1, 1);
    chk("R3 threshold 4 reached", 1'b1, 4'd4);
    mb(1'b0, 1);
    chk("R5 single clean clears", 1'b0, 4'd0);

    // R1 asynchronous reset with alarm raised
    mb(1'b1, 4);
    chk("R1 alarm before reset", 1'b1, 4'd4);
    @(negedge clk);
    rst_ni = 1'b0;
    #5;
    chk("R1 reset clears alarm", 1'b0, 4'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    mb(1'b0, 1);
    chk("R1 post-reset clean", 1'b0, 4'd0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule